// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block holds the time of day and the calendar date as seven packed-BCD bytes: seconds, minutes, hours (24-hour), day of week, day of month, month and a two-digit year. The hours byte also carries a century flag and an enable for it. A one-cycle `tick_i` enable, produced once per second by an external prescaler, advances the count. Carries run through every field. Month lengths and leap years are handled in the counter itself.

A host sets the time through a byte-wide write port. A stop bit in the seconds byte freezes timekeeping. While the host reads the clock bytes it raises `rd_hold_i`. The visible registers then stay frozen for the length of the read. Ticks that arrive during the read are counted and applied, one per clock, once the read window closes, so no time is lost.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the bytes read seconds 00, minutes 00, hours 00 with the century enable and flag at 0, day of week 01, date 01, month 01 and year 00.
- R2: Seconds and minutes count 00 to 59 and hours count 00 to 23, each in BCD. A wrap returns the field to 00 and advances the next field on the same tick.
- R3: Bit 7 of the seconds byte is a stop flag. While it is 1, ticks have no effect on any byte and queued ticks are dropped. Once it is written back to 0, each tick advances the count again.
- R4: At each midnight rollover the day of week steps by one and wraps from 07 to 01, whatever the date does.
- R5: Bit 7 of the hours byte enables the century flag and bit 6 is the flag. When the year wraps from 99 to 00, the flag inverts if the enable is 1 and keeps its value if the enable is 0.
- R6: The date wraps to 01 after the last day of the month: 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11. Month 12 wraps to 01 and advances the year.
- R7: February has 29 days when the BCD year is a multiple of four (00 counts as one) and 28 days otherwise.
- R8: While `rd_hold_i` is 1, no byte changes because of a tick. Ticks seen in that time are queued, up to 2^PEND_W-1 (3 by default). After the hold drops, they are applied one per clock.
- R9: Bits with no meaning are stored and read as 0. These are minutes bit 7, day-of-week bits 7:3, date bits 7:6 and month bits 7:5.
- R10: A write to the seconds byte (select 0) discards every queued tick, including a tick that arrives in the same cycle.
- R11: A tick that arrives in the same cycle as a write to any other byte is not lost. It is applied on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second advance enable, one cycle wide |
| rd_hold_i | input | 1 | High while a host read of the clock bytes is in progress |
| wr_en_i | input | 1 | Byte write strobe |
| wr_sel_i | input | 3 | Byte select: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year |
| wr_data_i | input | 8 | Write data |
| sec_o | output | 8 | Stop flag and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Century enable, century flag and BCD hours |
| dow_o | output | 8 | Day of week |
| date_o | output | 8 | BCD day of month |
| mon_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |

## Verification
The main vectors preset the calendar to instants just before a boundary and apply one tick.
- A plain second step, a minute carry and a BCD digit carry in hours check the low fields, and each of them also shows that no carry leaks into the higher fields.
- Month ends cover 30-day and 31-day months and February in years 21, 24, 12, 10 and 00. These separate a 28-day February from a 29-day one under both the even-tens and the odd-tens leap patterns.
- Year wraps with the century enable on and off tell a toggling flag from a held one. A 98-to-99 step shows that the flag stays untouched when there is no wrap.
- Directed sequences cover deferral under a read hold, queue saturation, a seconds write that flushes the queue, a tick that collides with a write, the stop flag and the zero bits.

// File: rtl/cal_pkg.sv
package cal_pkg;

   localparam int NREG = 7;
   localparam int DW   = 8;

   typedef enum logic [2:0] {
      SEL_SEC  = 3'd0,
      SEL_MIN  = 3'd1,
      SEL_HOUR = 3'd2,
      SEL_DOW  = 3'd3,
      SEL_DATE = 3'd4,
      SEL_MON  = 3'd5,
      SEL_YEAR = 3'd6
   } cal_sel_e;

   localparam int STOP_BIT   = 7;
   localparam int CEN_EN_BIT = 7;
   localparam int CEN_BIT    = 6;

   // bits kept on a host write
   localparam logic [DW-1:0] WR_MASK [NREG] =
      '{8'hFF, 8'h7F, 8'hFF, 8'h07, 8'h3F, 8'h1F, 8'hFF};
   // bits that form the counted value of each byte
   localparam logic [DW-1:0] FIELD_MASK [NREG] =
      '{8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};
   // value each field returns to when it wraps
   localparam int unsigned FIELD_LO [NREG] =
      '{0, 0, 0, 1, 1, 1, 0};
   localparam logic [DW-1:0] RST_VAL [NREG] =
      '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};

   function automatic logic [DW-1:0] bcd_inc(input logic [DW-1:0] v);
      logic [DW-1:0] r;
      if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
      else                r = v + 8'd1;
      return r;
   endfunction

endpackage

// File: rtl/cal_month_len.sv
module cal_month_len
   import cal_pkg::*;
(
   input  logic [DW-1:0] mon_i,
   input  logic [DW-1:0] year_i,
   output logic [DW-1:0] last_day_o
);

   logic leap;

   // multiple of four in BCD: even tens -> units 0/4/8, odd tens -> units 2/6
   always_comb begin
      if (year_i[4]) leap = (year_i[3:0] == 4'd2) || (year_i[3:0] == 4'd6);
      else           leap = (year_i[3:0] == 4'd0) || (year_i[3:0] == 4'd4) ||
                            (year_i[3:0] == 4'd8);
   end

   always_comb begin
      unique case (mon_i)
         8'h02:                      last_day_o = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
         default:                    last_day_o = 8'h31;
      endcase
   end

endmodule

// File: rtl/cal_bcd_wrap.sv
module cal_bcd_wrap
   import cal_pkg::*;
#(
   parameter int unsigned LO = 0
)(
   input  logic [DW-1:0] val_i,
   input  logic [DW-1:0] hi_i,
   output logic [DW-1:0] nxt_o,
   output logic          at_max_o
);

   if (LO > 9) begin : g_bad_lo
      $error("cal_bcd_wrap: LO must be a single BCD digit");
   end

   // values at or beyond the limit wrap, so an out-of-range write recovers
   assign at_max_o = (val_i >= hi_i);
   assign nxt_o    = at_max_o ? DW'(LO) : bcd_inc(val_i);

endmodule

// File: rtl/cal_tick_queue.sv
module cal_tick_queue #(
   parameter int PEND_W = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic hold_i,
   input  logic busy_i,
   input  logic flush_i,
   output logic adv_o
);

   if (PEND_W < 1 || PEND_W > 8) begin : g_bad_pend
      $error("cal_tick_queue: PEND_W out of range 1..8");
   end

   localparam logic [PEND_W-1:0] PMAX = {PEND_W{1'b1}};

   logic [PEND_W-1:0] pend_q, pend_d;
   logic              blocked, have;

   assign blocked = hold_i | busy_i;
   assign have    = (pend_q != '0);
   assign adv_o   = !flush_i && !blocked && (tick_i || have);

   always_comb begin
      pend_d = pend_q;
      if (flush_i)                        pend_d = '0;
      else if (blocked) begin
         if (tick_i && pend_q != PMAX)    pend_d = pend_q + 1'b1;
      end else if (!tick_i && have)       pend_d = pend_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> pend_q == '0); // R10
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_i && hold_i && tick_i && pend_q == PMAX) |=> pend_q == PMAX); // R8
   AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_i && !blocked && !tick_i && have) |=> pend_q == $past(pend_q) - 1'b1); // R8

endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
   import cal_pkg::*;
#(
   parameter int PEND_W = 2
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          rd_hold_i,
   input  logic          wr_en_i,
   input  logic [2:0]    wr_sel_i,
   input  logic [DW-1:0] wr_data_i,
   output logic [DW-1:0] sec_o,
   output logic [DW-1:0] min_o,
   output logic [DW-1:0] hour_o,
   output logic [DW-1:0] dow_o,
   output logic [DW-1:0] date_o,
   output logic [DW-1:0] mon_o,
   output logic [DW-1:0] year_o
);

   logic [DW-1:0]   regs_q [NREG];
   logic [DW-1:0]   hi     [NREG];
   logic [DW-1:0]   nxt    [NREG];
   logic [NREG-1:0] at_max;
   logic [NREG-1:0] en;
   logic [DW-1:0]   last_day;
   logic            adv, stopped, sec_wr;

   assign stopped = regs_q[SEL_SEC][STOP_BIT];
   assign sec_wr  = wr_en_i && (wr_sel_i == SEL_SEC);

   cal_tick_queue #(.PEND_W(PEND_W)) u_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .hold_i  (rd_hold_i),
      .busy_i  (wr_en_i),
      .flush_i (stopped | sec_wr),
      .adv_o   (adv)
   );

   cal_month_len u_mlen (
      .mon_i      (regs_q[SEL_MON]),
      .year_i     (regs_q[SEL_YEAR]),
      .last_day_o (last_day)
   );

   always_comb begin
      hi[SEL_SEC]  = 8'h59;
      hi[SEL_MIN]  = 8'h59;
      hi[SEL_HOUR] = 8'h23;
      hi[SEL_DOW]  = 8'h07;
      hi[SEL_DATE] = last_day;
      hi[SEL_MON]  = 8'h12;
      hi[SEL_YEAR] = 8'h99;
   end

   for (genvar g = 0; g < NREG; g++) begin : g_field
      cal_bcd_wrap #(.LO(FIELD_LO[g])) u_wrap (
         .val_i    (regs_q[g] & FIELD_MASK[g]),
         .hi_i     (hi[g]),
         .nxt_o    (nxt[g]),
         .at_max_o (at_max[g])
      );
   end

   // carry chain: day of week and date both step at midnight
   always_comb begin
      en[SEL_SEC]  = adv;
      en[SEL_MIN]  = adv && at_max[SEL_SEC];
      en[SEL_HOUR] = adv && at_max[SEL_SEC] && at_max[SEL_MIN];
      en[SEL_DOW]  = en[SEL_HOUR] && at_max[SEL_HOUR];
      en[SEL_DATE] = en[SEL_HOUR] && at_max[SEL_HOUR];
      en[SEL_MON]  = en[SEL_DATE] && at_max[SEL_DATE];
      en[SEL_YEAR] = en[SEL_MON]  && at_max[SEL_MON];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs_q[i] <= RST_VAL[i];
      end else if (wr_en_i) begin
         if (wr_sel_i < 3'(NREG)) regs_q[wr_sel_i] <= wr_data_i & WR_MASK[wr_sel_i];
      end else begin
         for (int i = 0; i < NREG; i++) begin
            if (en[i]) regs_q[i] <= (regs_q[i] & ~FIELD_MASK[i]) | (nxt[i] & FIELD_MASK[i]);
         end
         if (en[SEL_YEAR] && at_max[SEL_YEAR] && regs_q[SEL_HOUR][CEN_EN_BIT])
            regs_q[SEL_HOUR][CEN_BIT] <= ~regs_q[SEL_HOUR][CEN_BIT];
      end
   end

   assign sec_o  = regs_q[SEL_SEC];
   assign min_o  = regs_q[SEL_MIN];
   assign hour_o = regs_q[SEL_HOUR];
   assign dow_o  = regs_q[SEL_DOW];
   assign date_o = regs_q[SEL_DATE];
   assign mon_o  = regs_q[SEL_MON];
   assign year_o = regs_q[SEL_YEAR];

   AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && sec_o[6:0] == 7'h59) |=> sec_o[6:0] == 7'h00); // R2
   AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_o[STOP_BIT] && !wr_en_i) |=> $stable(sec_o) && $stable(min_o)); // R3
   AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (en[SEL_DOW] && dow_o == 8'h07) |=> dow_o == 8'h01); // R4
   AST_CENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en[SEL_YEAR] && !hour_o[CEN_EN_BIT]) |=> $stable(hour_o[CEN_BIT])); // R5
   AST_MON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (en[SEL_MON] && mon_o == 8'h12) |=> mon_o == 8'h01); // R6
   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hold_i && !wr_en_i) |=> $stable(sec_o) && $stable(date_o) && $stable(year_o)); // R8

endmodule

// File: tb/test_bcd_calendar_core.sv
`timescale 1ns/1ps
module test_bcd_calendar_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       rd_hold_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [2:0] wr_sel_i = 3'd0;
   logic [7:0] wr_data_i = 8'h00;
   logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, mon_o, year_o;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   bcd_calendar_core i_bcd_calendar_core (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rd_hold_i(rd_hold_i),
      .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
      .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
      .date_o(date_o), .mon_o(mon_o), .year_o(year_o)
   );

   // {preset sec,min,hour,dow,date,mon,year ; expected after one tick}
   localparam int NV = 17;
   localparam logic [111:0] VEC [NV] = '{
      {56'h00_00_00_01_01_01_00, 56'h01_00_00_01_01_01_00},
      {56'h59_09_05_02_10_06_21, 56'h00_10_05_02_10_06_21},
      {56'h59_59_23_07_15_03_21, 56'h00_00_00_01_16_03_21},
      {56'h59_59_23_03_31_01_21, 56'h00_00_00_04_01_02_21},
      {56'h59_59_23_02_28_02_21, 56'h00_00_00_03_01_03_21},
      {56'h59_59_23_02_28_02_24, 56'h00_00_00_03_29_02_24},
      {56'h59_59_23_03_29_02_24, 56'h00_00_00_04_01_03_24},
      {56'h59_59_23_05_30_04_21, 56'h00_00_00_06_01_05_21},
      {56'h59_59_E3_05_31_12_99, 56'h00_00_80_06_01_01_00},
      {56'h59_59_63_05_31_12_99, 56'h00_00_40_06_01_01_00},
      {56'h59_59_A3_05_31_12_98, 56'h00_00_80_06_01_01_99},
      {56'h59_59_23_01_28_02_12, 56'h00_00_00_02_29_02_12},
      {56'h59_59_23_01_28_02_10, 56'h00_00_00_02_01_03_10},
      {56'h59_59_23_04_30_11_21, 56'h00_00_00_05_01_12_21},
      {56'h59_59_09_04_14_07_21, 56'h00_00_10_04_14_07_21},
      {56'h59_59_23_06_31_05_21, 56'h00_00_00_07_01_06_21},
      {56'h59_59_23_01_28_02_00, 56'h00_00_00_02_29_02_00}
   };

   function automatic logic [55:0] all_regs();
      return {sec_o, min_o, hour_o, dow_o, date_o, mon_o, year_o};
   endfunction

   task automatic check(input string req, input logic [55:0] got, input logic [55:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic write_reg(input logic [2:0] sel, input logic [7:0] data);
      @(negedge clk);
      wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic pulse_tick();
      @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
   endtask

   task automatic load(input logic [55:0] v);
      for (int k = 0; k < 7; k++) write_reg(3'(k), v[55 - 8*k -: 8]);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset state", all_regs(), 56'h00_00_00_01_01_01_00);

      // vector table: R2 R4 R5 R6 R7
      for (int v = 0; v < NV; v++) begin
         load(VEC[v][111:56]);
         pulse_tick();
         check($sformatf("vector %0d (R2 R4 R5 R6 R7)", v), all_regs(), VEC[v][55:0]);
      end

      // R9: meaningless bits read as zero
      write_reg(3'd1, 8'hFF); check("R9 minutes bit7", 56'(min_o),  56'h7F);
      write_reg(3'd3, 8'hFF); check("R9 day of week",  56'(dow_o),  56'h07);
      write_reg(3'd4, 8'hFF); check("R9 date",         56'(date_o), 56'h3F);
      write_reg(3'd5, 8'hFF); check("R9 month",        56'(mon_o),  56'h1F);

      // R3: stop flag freezes, clearing resumes
      load(56'h90_05_10_02_10_06_21);
      pulse_tick();
      pulse_tick();
      check("R3 stopped", all_regs(), 56'h90_05_10_02_10_06_21);
      write_reg(3'd0, 8'h10);
      pulse_tick();
      check("R3 resumed", 56'(sec_o), 56'h11);

      // R8: deferral under read hold
      load(56'h10_05_10_02_10_06_21);
      @(negedge clk); rd_hold_i = 1'b1;
      pulse_tick();
      pulse_tick();
      check("R8 frozen during hold", all_regs(), 56'h10_05_10_02_10_06_21);
      @(negedge clk); rd_hold_i = 1'b0;
      repeat (3) @(negedge clk);
      check("R8 queued ticks applied", 56'(sec_o), 56'h12);

      // R8: queue saturates at three
      load(56'h20_05_10_02_10_06_21);
      @(negedge clk); rd_hold_i = 1'b1;
      for (int t = 0; t < 5; t++) pulse_tick();
      @(negedge clk); rd_hold_i = 1'b0;
      repeat (6) @(negedge clk);
      check("R8 saturation", 56'(sec_o), 56'h23);

      // R10: seconds write flushes queue
      load(56'h10_05_10_02_10_06_21);
      @(negedge clk); rd_hold_i = 1'b1;
      pulse_tick();
      write_reg(3'd0, 8'h30);
      @(negedge clk); rd_hold_i = 1'b0;
      repeat (3) @(negedge clk);
      check("R10 queue flushed", 56'(sec_o), 56'h30);

      // R10: tick coincident with seconds write is dropped
      @(negedge clk);
      tick_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 3'd0; wr_data_i = 8'h45;
      @(negedge clk);
      tick_i = 1'b0; wr_en_i = 1'b0;
      repeat (2) @(negedge clk);
      check("R10 coincident tick dropped", 56'(sec_o), 56'h45);

      // R11: tick coincident with another write is deferred
      load(56'h40_05_10_02_10_06_21);
      @(negedge clk);
      tick_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 3'd1; wr_data_i = 8'h22;
      @(negedge clk);
      tick_i = 1'b0; wr_en_i = 1'b0;
      check("R11 write cycle", {sec_o, min_o}, {8'h40, 8'h22});
      @(negedge clk);
      check("R11 deferred tick", 56'(sec_o), 56'h41);

      finish_run();
   end

endmodule